// File: doc/BRIEF.md
# Multiplierless Transposed FIR Filter

This block is a fixed-coefficient FIR filter in transposed form. It takes one input sample per clock and gives one full-precision result per clock. Each accepted sample feeds a single shared network of shifts and adds. That network forms the sample's product with every tap coefficient in the same cycle. The products then enter a chain of registered adders, and the head of the chain is the filter output. The datapath contains no multiplier.

Each coefficient is an elaboration-time parameter written in canonical signed-digit form, as two digit masks: one for the +1 digits and one for the -1 digits. The network builds two shared terms for every digit spacing d, namely x·(2^d+1) and x·(2^d−1). Any tap that holds a pair of nonzero digits at that spacing reuses the same term after a free shift. The remaining terms of a tap are summed in a small balanced tree. The input may be signed or unsigned. The output width is sized so that no sum can overflow. Changing a coefficient changes the adder network, so the design must be re-elaborated.

Top module: `fir_mcm_transposed`

## Requirements
- R1: In every cycle with `in_valid` high, the sample is accepted. On the following clock edge, `out_data` becomes Σ h[k]·x[n−k] over the accepted samples, with x[n] the newest sample and missing history counted as zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: Let XW be DATA_W for signed input and DATA_W+1 for unsigned input. `out_data` is signed with width XW + clog2(Σ|h[k]|). Every reachable result, including the largest-magnitude one, appears without wrap or rounding.
- R4: Each tap product is built only from shifts and add/subtract operations. The spacing terms x·(2^d±1) are computed once and shared by all taps. There are at most MAX_ADDER_DEPTH adder levels (default 4) from the input to any product. Each product equals h[k]·x exactly, in the same cycle.
- R5: Bit k·DIG_W+i of `POS_DIGITS` (or of `NEG_DIGITS`) is the +1 (or −1) digit of weight 2^i of tap k, so h[k] = pos − neg. Tap 0 weights the newest sample. Elaboration rejects masks with a digit set in both masks or two adjacent nonzero digits, a coefficient set whose Σ|h| is below 2, or a DIG_W whose tree exceeds the depth limit.
- R6: With `IN_SIGNED` = 0, `in_data` is read as an unsigned value (zero-extended). With `IN_SIGNED` = 1, it is read as two's complement.
- R7: In a cycle with `in_valid` low, nothing is accepted, `out_data` and the adder chain hold their values, and later results are the same as if that cycle had not occurred.
- R8: A synchronous `rst` clears the whole chain and `out_valid`. `out_data` reads 0, and later results treat all earlier history as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample, signed or unsigned per IN_SIGNED |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | ACC_W | Signed full-precision filter result |

## Verification
The bench builds two copies of the filter with the same asymmetric six-tap set {3, −5, 13, −5, 3, −85}. One copy takes 8-bit signed input (15-bit output) and the other takes 6-bit unsigned input (14-bit output). The −85 tap has four nonzero digits, so it exercises the two-level summing tree. The other taps use both the (2^d+1) and (2^d−1) shared terms and a lone leftover digit. Because the set is asymmetric, a reversed tap order would show up at once. The unsigned copy exercises the zero-extension path and mixed-sign results from unsigned data. The signed copy is driven with the sign-matched extreme pattern that reaches the largest output magnitude.

// File: rtl/fir_mcm_pkg.sv
package fir_mcm_pkg;

  localparam int MASK_BITS = 1024;
  typedef logic [MASK_BITS-1:0] mask_t;

  // Signed value of one tap from its two digit masks (Horner, shifts only).
  function automatic int csd_coef(mask_t pos, mask_t neg, int tap, int dig_w);
    int v;
    v = 0;
    for (int i = dig_w - 1; i >= 0; i--) begin
      v = (v <<< 1) + int'(pos[tap*dig_w+i]) - int'(neg[tap*dig_w+i]);
    end
    return v;
  endfunction

  function automatic int abs_sum(mask_t pos, mask_t neg, int taps, int dig_w);
    int s;
    int c;
    s = 0;
    for (int k = 0; k < taps; k++) begin
      c = csd_coef(pos, neg, k, dig_w);
      s += (c < 0) ? -c : c;
    end
    return s;
  endfunction

  function automatic int out_width(mask_t pos, mask_t neg, int taps, int dig_w,
                                   int data_w, bit in_signed);
    return data_w + (in_signed ? 0 : 1) + $clog2(abs_sum(pos, neg, taps, dig_w));
  endfunction

  // Canonical form: no digit in both masks, no two neighbouring nonzero digits.
  function automatic bit csd_legal(mask_t pos, mask_t neg, int taps, int dig_w);
    bit ok;
    ok = 1'b1;
    for (int k = 0; k < taps; k++) begin
      for (int i = 0; i < dig_w; i++) begin
        if (pos[k*dig_w+i] && neg[k*dig_w+i]) ok = 1'b0;
        if (i + 1 < dig_w &&
            (pos[k*dig_w+i] || neg[k*dig_w+i]) &&
            (pos[k*dig_w+i+1] || neg[k*dig_w+i+1])) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  // Shared spacing term (1 level) plus a balanced tree over the pair terms.
  function automatic int net_depth(int dig_w);
    int nz;
    int terms;
    nz    = (dig_w + 1) / 2;
    terms = (nz + 1) / 2;
    return 1 + $clog2(terms);
  endfunction

endpackage

// File: rtl/mcm_shared_terms.sv
module mcm_shared_terms #(
  parameter int W     = 16,
  parameter int DIG_W = 8
) (
  input  logic signed [W-1:0]       xe,
  output logic [DIG_W*W-1:0]        sum_bus,
  output logic [DIG_W*W-1:0]        dif_bus
);
  // One adder and one subtractor per digit spacing, shared by every tap.
  for (genvar d = 0; d < DIG_W; d++) begin : g_span
    logic signed [W-1:0] up;
    assign up = xe <<< d;
    assign sum_bus[d*W +: W] = up + xe;
    assign dif_bus[d*W +: W] = up - xe;
  end
endmodule

// File: rtl/csd_tap_product.sv
module csd_tap_product #(
  parameter int              W     = 16,
  parameter int              DIG_W = 8,
  parameter logic [DIG_W-1:0] POS  = '0,
  parameter logic [DIG_W-1:0] NEG  = '0
) (
  input  logic signed [W-1:0] xe,
  input  logic [DIG_W*W-1:0]  sum_bus,
  input  logic [DIG_W*W-1:0]  dif_bus,
  output logic signed [W-1:0] prod
);
  localparam int MAX_NZ = (DIG_W + 1) / 2;
  localparam int TERMS  = (MAX_NZ + 1) / 2;
  localparam int TP2    = 1 << $clog2(TERMS);

  logic signed [W-1:0] terms [TP2];
  logic signed [W-1:0] base;
  logic signed [W-1:0] shifted;
  int                  n;
  int                  lo_pos;
  int                  span;
  logic                have_lo;
  logic                lo_neg;

  always_comb begin
    for (int t = 0; t < TP2; t++) terms[t] = '0;
    n = 0; lo_pos = 0; span = 0; have_lo = 1'b0; lo_neg = 1'b0;
    base = '0; shifted = '0;
    // Pair nonzero digits from the low end: s_hi*2^a + s_lo*2^b = s_hi*2^b*(2^d +/- 1).
    for (int k = 0; k < DIG_W; k++) begin
      if (POS[k] || NEG[k]) begin
        if (!have_lo) begin
          have_lo = 1'b1;
          lo_pos  = k;
          lo_neg  = NEG[k];
        end else begin
          span     = k - lo_pos;
          base     = (NEG[k] == lo_neg) ? sum_bus[span*W +: W] : dif_bus[span*W +: W];
          shifted  = base <<< lo_pos;
          terms[n] = NEG[k] ? -shifted : shifted;
          n        = n + 1;
          have_lo  = 1'b0;
        end
      end
    end
    if (have_lo) begin
      shifted  = xe <<< lo_pos;
      terms[n] = lo_neg ? -shifted : shifted;
    end
    // Balanced reduction tree.
    for (int s = 1; s < TP2; s = s << 1) begin
      for (int i = 0; i + s < TP2; i = i + (s << 1)) begin
        terms[i] = terms[i] + terms[i+s];
      end
    end
    prod = terms[0];
  end
endmodule

// File: rtl/transposed_chain.sv
module transposed_chain #(
  parameter int W        = 16,
  parameter int NUM_TAPS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [NUM_TAPS*W-1:0]   prod_bus,
  output logic signed [W-1:0]     y
);
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_stage
    logic signed [W-1:0] r;
    logic signed [W-1:0] p;
    assign p = prod_bus[k*W +: W];
    if (k == NUM_TAPS - 1) begin : g_tail
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (adv) r <= p;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)      r <= '0;
        else if (adv) r <= p + g_stage[k+1].r;
      end
    end
  end
  assign y = g_stage[0].r;
endmodule

// File: rtl/fir_mcm_transposed.sv
module fir_mcm_transposed #(
  parameter int  DATA_W          = 8,
  parameter bit  IN_SIGNED       = 1'b1,
  parameter int  NUM_TAPS        = 6,
  parameter int  DIG_W           = 8,
  parameter int  MAX_ADDER_DEPTH = 4,
  parameter logic [NUM_TAPS*DIG_W-1:0] POS_DIGITS = 48'h00_04_00_11_00_04,
  parameter logic [NUM_TAPS*DIG_W-1:0] NEG_DIGITS = 48'h55_01_05_04_05_01,
  localparam int ACC_W = fir_mcm_pkg::out_width(
      fir_mcm_pkg::MASK_BITS'(POS_DIGITS), fir_mcm_pkg::MASK_BITS'(NEG_DIGITS),
      NUM_TAPS, DIG_W, DATA_W, IN_SIGNED)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);
  localparam int COEF_SUM = fir_mcm_pkg::abs_sum(
      fir_mcm_pkg::MASK_BITS'(POS_DIGITS), fir_mcm_pkg::MASK_BITS'(NEG_DIGITS),
      NUM_TAPS, DIG_W);
  localparam bit DIGITS_OK = fir_mcm_pkg::csd_legal(
      fir_mcm_pkg::MASK_BITS'(POS_DIGITS), fir_mcm_pkg::MASK_BITS'(NEG_DIGITS),
      NUM_TAPS, DIG_W);
  localparam int DEPTH = fir_mcm_pkg::net_depth(DIG_W);

  if (!DIGITS_OK) begin : g_bad_digits
    $error("coefficient digit masks are not in canonical signed-digit form");
  end
  if (DEPTH > MAX_ADDER_DEPTH) begin : g_too_deep
    $error("product network depth exceeds MAX_ADDER_DEPTH");
  end
  if (COEF_SUM < 2 || NUM_TAPS < 2) begin : g_too_small
    $error("coefficient set too small for this structure");
  end

  // Internal arithmetic runs at ACC_W: every final product and partial sum
  // fits there, so modular wrap in intermediate terms cancels out.
  logic signed [ACC_W-1:0]     xe_w;
  logic [DIG_W*ACC_W-1:0]      sum_bus;
  logic [DIG_W*ACC_W-1:0]      dif_bus;
  logic [NUM_TAPS*ACC_W-1:0]   prod_bus;
  logic signed [ACC_W-1:0]     chain_head;

  if (IN_SIGNED) begin : g_sext
    assign xe_w = {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data};
  end else begin : g_zext
    assign xe_w = {{(ACC_W-DATA_W){1'b0}}, in_data};
  end

  mcm_shared_terms #(.W(ACC_W), .DIG_W(DIG_W)) u_terms (
    .xe      (xe_w),
    .sum_bus (sum_bus),
    .dif_bus (dif_bus)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    csd_tap_product #(
      .W     (ACC_W),
      .DIG_W (DIG_W),
      .POS   (POS_DIGITS[k*DIG_W +: DIG_W]),
      .NEG   (NEG_DIGITS[k*DIG_W +: DIG_W])
    ) u_prod (
      .xe      (xe_w),
      .sum_bus (sum_bus),
      .dif_bus (dif_bus),
      .prod    (prod_bus[k*ACC_W +: ACC_W])
    );
  end

  transposed_chain #(.W(ACC_W), .NUM_TAPS(NUM_TAPS)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .adv      (in_valid),
    .prod_bus (prod_bus),
    .y        (chain_head)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  assign out_data = chain_head;
endmodule

// File: rtl/fir_mcm_checker.sv
module fir_mcm_checker #(
  parameter int DATA_W    = 8,
  parameter bit IN_SIGNED = 1'b1,
  parameter int NUM_TAPS  = 6,
  parameter int DIG_W     = 8,
  parameter logic [NUM_TAPS*DIG_W-1:0] POS_DIGITS = '0,
  parameter logic [NUM_TAPS*DIG_W-1:0] NEG_DIGITS = '0,
  parameter int ACC_W     = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [DATA_W-1:0]        in_data,
  input logic                     out_valid,
  input logic signed [ACC_W-1:0]  out_data,
  input logic [NUM_TAPS*ACC_W-1:0] prod_bus
);
  localparam longint LIM = longint'(fir_mcm_pkg::abs_sum(
      fir_mcm_pkg::MASK_BITS'(POS_DIGITS), fir_mcm_pkg::MASK_BITS'(NEG_DIGITS),
      NUM_TAPS, DIG_W)) <<< (IN_SIGNED ? DATA_W - 1 : DATA_W);

  logic signed [ACC_W-1:0] x_chk;
  assign x_chk = IN_SIGNED ? ACC_W'($signed(in_data)) : ACC_W'(in_data);

  // R4: each shift-add product equals coefficient times sample.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int C = fir_mcm_pkg::csd_coef(
        fir_mcm_pkg::MASK_BITS'(POS_DIGITS), fir_mcm_pkg::MASK_BITS'(NEG_DIGITS), k, DIG_W);
    logic signed [ACC_W-1:0] c_w;
    assign c_w = ACC_W'(C);
    p_tap_product_r4: assert property (@(posedge clk) disable iff (rst)
      $signed(prod_bus[k*ACC_W +: ACC_W]) == c_w * x_chk);
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (out_data == '0 && !out_valid));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_data) <= LIM && longint'(out_data) >= -LIM));
endmodule

bind fir_mcm_transposed fir_mcm_checker #(
  .DATA_W     (DATA_W),
  .IN_SIGNED  (IN_SIGNED),
  .NUM_TAPS   (NUM_TAPS),
  .DIG_W      (DIG_W),
  .POS_DIGITS (POS_DIGITS),
  .NEG_DIGITS (NEG_DIGITS),
  .ACC_W      (ACC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .prod_bus  (prod_bus)
);

// File: tb/fir_mcm_transposed_bench.sv
`timescale 1ns/1ps
module fir_mcm_transposed_bench;
  localparam int TAPS = 6;
  localparam logic [47:0] POS = 48'h00_04_00_11_00_04;
  localparam logic [47:0] NEG = 48'h55_01_05_04_05_01;
  localparam int H [TAPS] = '{3, -5, 13, -5, 3, -85};
  localparam int SW = 15;  // R3: 8 + clog2(114)
  localparam int UW = 14;  // R3: (6+1) + clog2(114)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] xs_in = '0;
  logic [5:0] xu_in = '0;
  logic vs, vu;
  logic [SW-1:0] ys;
  logic [UW-1:0] yu;

  fir_mcm_transposed #(.DATA_W(8), .IN_SIGNED(1'b1), .NUM_TAPS(TAPS), .DIG_W(8),
                       .POS_DIGITS(POS), .NEG_DIGITS(NEG)) u_fir_mcm_transposed (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(xs_in),
    .out_valid(vs), .out_data(ys));

  fir_mcm_transposed #(.DATA_W(6), .IN_SIGNED(1'b0), .NUM_TAPS(TAPS), .DIG_W(8),
                       .POS_DIGITS(POS), .NEG_DIGITS(NEG)) u_fir_mcm_transposed_uns (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(xu_in),
    .out_valid(vu), .out_data(yu));

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int hs[$];
  int hu[$];
  int exp_s = 0;
  int exp_u = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int conv(int q[$]);
    int s = 0;
    for (int k = 0; k < TAPS && k < q.size(); k++) s += H[k] * q[k];
    return s;
  endfunction

  // Drive at a falling edge, compare at the next falling edge.
  task automatic step(input bit v, input int xs, input int xu, input string tag);
    string dtag;
    in_valid = v;
    xs_in = 8'(xs);
    xu_in = 6'(xu);
    if (v) begin
      hs.push_front(xs);
      hu.push_front(xu);
      if (hs.size() > TAPS) void'(hs.pop_back());
      if (hu.size() > TAPS) void'(hu.pop_back());
      exp_s = conv(hs);
      exp_u = conv(hu);
    end
    @(negedge clk);
    dtag = v ? tag : "R7";
    check(vs == v && vu == v, "R2", "out_valid", int'(vs), int'(v));
    check(int'($signed(ys)) == exp_s, dtag, "signed out_data", int'($signed(ys)), exp_s);
    check(int'($signed(yu)) == exp_u, v ? "R6" : "R7", "unsigned out_data",
          int'($signed(yu)), exp_u);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    hs.delete();
    hu.delete();
    exp_s = 0;
    exp_u = 0;
    check(ys == '0 && yu == '0, "R8", "out_data after reset", int'($signed(ys)), 0);
    check(!vs && !vu, "R8", "out_valid after reset", int'(vs), 0);
    rst = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    do_reset(3);
    check($bits(u_fir_mcm_transposed.out_data) == SW, "R3", "signed width",
          $bits(u_fir_mcm_transposed.out_data), SW);
    check($bits(u_fir_mcm_transposed_uns.out_data) == UW, "R3", "unsigned width",
          $bits(u_fir_mcm_transposed_uns.out_data), UW);

    // R5: unit impulse reads the coefficients back, newest tap first.
    step(1'b1, 1, 1, "R5");
    for (int i = 0; i < TAPS + 1; i++) step(1'b1, 0, 0, "R5");

    // R1: negative step then positive step.
    for (int i = 0; i < 8; i++) step(1'b1, -7, 9, "R1");
    for (int i = 0; i < 8; i++) step(1'b1, 11, 40, "R1");

    // R7: gaps in the strobe between samples.
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 20 - 5 * i, 3 * i, "R1");
      step(1'b0, 99, 55, "R7");
      if (i % 3 == 0) step(1'b0, -99, 17, "R7");
    end

    // R3: sign-matched extremes give the largest magnitude.
    for (int k = TAPS - 1; k >= 0; k--)
      step(1'b1, (H[k] > 0) ? -128 : 127, (H[k] < 0) ? 63 : 0, "R3");
    for (int k = TAPS - 1; k >= 0; k--)
      step(1'b1, (H[k] > 0) ? 127 : -128, (H[k] > 0) ? 63 : 0, "R3");

    // R1 R4: random data, random strobe.
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 255)) - 128,
           int'($urandom_range(0, 63)), "R1 R4");

    // R8: reset mid-stream, then history must read as zero.
    do_reset(2);
    step(1'b1, 2, 2, "R8");
    for (int i = 0; i < TAPS; i++) step(1'b1, 0, 0, "R8");

    summary();
    $finish;
  end
endmodule